// File: doc/BRIEF.md
# Password Check Unit with Per-Password Failure Counters

This unit keeps eight password sets. Each set holds one password for writing and one for reading, and every password has its own 8-bit counter of failed tries. A host presents a 4-bit selector and a 24-bit value. The unit compares the value against the chosen stored password, records the outcome in that password's counter, and then either records a single privilege or records none. The privilege is a set number and a flag that tells whether write rights or only read rights were granted. Per-set `read_ok` and `write_ok` vectors let the neighbouring memory logic decide what each zone may do.

A failure clears one more counter bit, shifting a zero in from the bottom. A success restores the counter to all ones. A counter that reaches zero freezes that password: further presentations of it change nothing and grant nothing. Each counter update takes `UPD_CYCLES` wait cycles, modelling a slow nonvolatile write. `busy` is high for the whole update, and the outcome appears only when `busy` falls. A card reset input withdraws the privilege. A holder of a write privilege may rewrite either password of its own set. An initialization port preloads passwords and counters for test.

The controller walks four states. `ST_IDLE` waits for a presentation. `ST_CHECK` compares the value and tests for exhaustion. `ST_WAIT` counts the update delay. `ST_COMMIT` writes the counter and the grant. The transitions are as follows:
- IDLE→CHECK on an accepted presentation.
- CHECK→IDLE when the counter is exhausted.
- CHECK→WAIT otherwise.
- WAIT→COMMIT when the delay count reaches zero.
- COMMIT→IDLE always.

Top module: `pwd_guard`

## Requirements
- R1: After `rst_n` all sixteen counters read 0xFF, `busy` is 0 and no privilege is held (`grant_valid`=0, `read_ok`=`write_ok`=0).
- R2: A selector is {r, set[2:0]}. r=0 picks the write password of the set and r=1 picks the read password. `cnt_sel`, `init_sel` and `pw_wr_sel` use the same encoding. Selector 4'b0111 (the write password of set 7) acts as the secure code and grants write rights to set 7.
- R3: A matching presentation on a non-zero counter sets that counter to 0xFF. It then holds `grant_valid`=1, `grant_set`=set and `grant_write`=!r.
- R4: A mismatching presentation on a non-zero counter shifts the counter left by one with a 0 entering bit 0 (0xFF→0xFE→0xFC, 0x80→0x00) and grants nothing.
- R5: A presentation whose counter is 0x00 leaves the counter at 0x00, grants nothing, and holds `busy` high for exactly one cycle.
- R6: At most one privilege exists. An accepted presentation drops any held privilege at the next clock edge, whatever its outcome.
- R7: `card_rst`=1 drops the held privilege at the next edge. It also cancels the grant of a presentation in progress, but that presentation's counter update still takes place.
- R8: A write privilege for set s sets both `read_ok[s]` and `write_ok[s]`. A read privilege for set s sets only `read_ok[s]`. All other bits are 0.
- R9: After an accepted, non-exhausted presentation, `busy` stays high for exactly `UPD_CYCLES`+2 cycles. `grant_valid` is 0 while `busy` is high.
- R10: While `busy` is high, presentations, initialization writes and rewrite requests have no effect.
- R11: A rewrite (`pw_wr_en`) of either password of set s takes effect only while a write privilege for set s is held. Any other rewrite has no effect.
- R12: While idle, `init_we` loads `init_data` into the password (`init_cnt`=0) or the low 8 bits into the counter (`init_cnt`=1) at `init_sel`.
- R13: A privilege stays held across idle cycles and across rewrites until R6 or R7 removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset of all state |
| card_rst | input | 1 | Card reset: withdraws privileges |
| pres_valid | input | 1 | Presentation strobe |
| pres_sel | input | 4 | Presentation selector {r,set} |
| pres_value | input | 24 | Presented password value |
| busy | output | 1 | Verification or counter update in progress |
| grant_valid | output | 1 | A privilege is held |
| grant_write | output | 1 | Held privilege carries write rights |
| grant_set | output | 3 | Set number of the held privilege |
| read_ok | output | 8 | Per-set read permission |
| write_ok | output | 8 | Per-set write permission |
| pw_wr_en | input | 1 | Password rewrite request |
| pw_wr_sel | input | 4 | Password to rewrite {r,set} |
| pw_wr_value | input | 24 | New password value |
| init_we | input | 1 | Initialization write strobe |
| init_cnt | input | 1 | 1: write a counter, 0: write a password |
| init_sel | input | 4 | Initialization target {r,set} |
| init_data | input | 24 | Initialization data |
| cnt_sel | input | 4 | Counter readback selector {r,set} |
| cnt_value | output | 8 | Selected counter value |

## Verification
Several properties are checked on every cycle. No privilege is visible while `busy` is high. At most one set can read and at most one set can write. Write permission always implies read permission for the same set. An accepted presentation or a card reset always empties the privilege at the next edge. A rewrite is only let through under a write privilege. Every counter update either restores all ones or is the one-bit left shift of the old value, and an update never touches a zero counter. The bench scenarios show the rest:
- which password actually matched, and the counter values that follow;
- the exact length of `busy`;
- that a card reset in mid-update still charges the counter;
- that requests made while busy, and rewrites outside a write privilege, leave no trace.

// File: rtl/pwd_guard_pkg.sv
package pwd_guard_pkg;

    // Controller states for one verification pass
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_CHECK  = 2'd1,
        ST_WAIT   = 2'd2,
        ST_COMMIT = 2'd3
    } vstate_t;

    // Kind of object written through the initialization port
    typedef enum logic {
        INIT_PASSWORD = 1'b0,
        INIT_COUNTER  = 1'b1
    } init_kind_t;

endpackage

// File: rtl/pwd_bank.sv
module pwd_bank #(
    parameter int N_SETS = 8,
    parameter int PW_W   = 24,
    parameter int CNT_W  = 8,
    localparam int IDX_W = $clog2(N_SETS) + 1,
    localparam int N_ENT = 2 * N_SETS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_we,
    input  logic             init_cnt,
    input  logic [IDX_W-1:0] init_idx,
    input  logic [PW_W-1:0]  init_data,
    input  logic             upd_we,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic [CNT_W-1:0] upd_cnt,
    input  logic             rw_we,
    input  logic [IDX_W-1:0] rw_idx,
    input  logic [PW_W-1:0]  rw_value,
    input  logic [IDX_W-1:0] cmp_idx,
    output logic [PW_W-1:0]  cmp_pw,
    output logic [CNT_W-1:0] cmp_cnt,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CNT_W-1:0] rd_cnt
);
    import pwd_guard_pkg::*;

    logic [PW_W-1:0]  pw_all  [N_ENT];
    logic [CNT_W-1:0] cnt_all [N_ENT];

    init_kind_t init_kind;
    assign init_kind = init_kind_t'(init_cnt);

    for (genvar e = 0; e < N_ENT; e++) begin : g_ent
        logic [PW_W-1:0]  pw_r;
        logic [CNT_W-1:0] cnt_r;
        logic             hit_init, hit_rw, hit_upd;

        assign hit_init = init_we && (init_idx == IDX_W'(e));
        assign hit_rw   = rw_we   && (rw_idx   == IDX_W'(e));
        assign hit_upd  = upd_we  && (upd_idx  == IDX_W'(e));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pw_r <= '0;
            end else if (hit_init && init_kind == INIT_PASSWORD) begin
                pw_r <= init_data;
            end else if (hit_rw) begin
                pw_r <= rw_value;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt_r <= '1;
            end else if (hit_upd) begin
                cnt_r <= upd_cnt;
            end else if (hit_init && init_kind == INIT_COUNTER) begin
                cnt_r <= init_data[CNT_W-1:0];
            end
        end

        assign pw_all[e]  = pw_r;
        assign cnt_all[e] = cnt_r;
    end

    assign cmp_pw  = pw_all[cmp_idx];
    assign cmp_cnt = cnt_all[cmp_idx];
    assign rd_cnt  = cnt_all[rd_idx];

    AST_FROZEN_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        upd_we |-> (cnt_all[upd_idx] != '0));                                  // R5
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        upd_we |=> ((cnt_all[$past(upd_idx)] == '1) ||
                    (cnt_all[$past(upd_idx)] == {$past(cnt_all[upd_idx][CNT_W-2:0]), 1'b0}))); // R4
endmodule

// File: rtl/pwd_fsm.sv
module pwd_fsm #(
    parameter int PW_W       = 24,
    parameter int CNT_W      = 8,
    parameter int IDX_W      = 4,
    parameter int UPD_CYCLES = 4,
    localparam int WAIT_W    = $clog2(UPD_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             card_rst,
    input  logic             pres_valid,
    input  logic [IDX_W-1:0] pres_idx,
    input  logic [PW_W-1:0]  pres_value,
    input  logic [PW_W-1:0]  cmp_pw,
    input  logic [CNT_W-1:0] cmp_cnt,
    output logic [IDX_W-1:0] cmp_idx,
    output logic             busy,
    output logic             accept,
    output logic             upd_we,
    output logic [IDX_W-1:0] upd_idx,
    output logic [CNT_W-1:0] upd_cnt,
    output logic             grant_we,
    output logic [IDX_W-1:0] grant_idx
);
    import pwd_guard_pkg::*;

    localparam logic [WAIT_W-1:0] WAIT_LOAD = WAIT_W'(UPD_CYCLES - 1);

    vstate_t            state_q, state_d;
    logic [IDX_W-1:0]   idx_q;
    logic [PW_W-1:0]    value_q;
    logic               match_q;
    logic               keep_q;
    logic [WAIT_W-1:0]  wait_q;

    assign accept = (state_q == ST_IDLE) && pres_valid;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (pres_valid)       state_d = ST_CHECK;
            ST_CHECK:  state_d = (cmp_cnt == '0) ? ST_IDLE : ST_WAIT;
            ST_WAIT:   if (wait_q == '0)     state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q   <= '0;
            value_q <= '0;
            match_q <= 1'b0;
            keep_q  <= 1'b0;
            wait_q  <= '0;
        end else begin
            if (accept) begin
                idx_q   <= pres_idx;
                value_q <= pres_value;
                keep_q  <= 1'b1;
            end
            if (card_rst) keep_q <= 1'b0;
            if (state_q == ST_CHECK) begin
                match_q <= (cmp_pw == value_q);
                wait_q  <= WAIT_LOAD;
            end else if (state_q == ST_WAIT && wait_q != '0) begin
                wait_q <= wait_q - 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        busy      = (state_q != ST_IDLE);
        cmp_idx   = idx_q;
        upd_idx   = idx_q;
        grant_idx = idx_q;
        upd_we    = (state_q == ST_COMMIT);
        upd_cnt   = match_q ? '1 : {cmp_cnt[CNT_W-2:0], 1'b0};
        grant_we  = (state_q == ST_COMMIT) && match_q && keep_q && !card_rst;
    end

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy);                                                       // R9
    AST_RST_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        card_rst |-> !grant_we);                                                // R7
    AST_IDLE_NO_UPD: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !upd_we);                                                     // R10
endmodule

// File: rtl/pwd_grant.sv
module pwd_grant #(
    parameter int N_SETS = 8,
    localparam int SET_W = $clog2(N_SETS),
    localparam int IDX_W = SET_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              revoke,
    input  logic              set_we,
    input  logic [IDX_W-1:0]  set_idx,
    input  logic              rw_req,
    input  logic [SET_W-1:0]  rw_set,
    output logic              grant_valid,
    output logic              grant_write,
    output logic [SET_W-1:0]  grant_set,
    output logic [N_SETS-1:0] read_ok,
    output logic [N_SETS-1:0] write_ok,
    output logic              rw_ok
);
    logic             valid_q, write_q;
    logic [SET_W-1:0] set_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            write_q <= 1'b0;
            set_q   <= '0;
        end else if (revoke) begin
            valid_q <= 1'b0;
            write_q <= 1'b0;
        end else if (set_we) begin
            valid_q <= 1'b1;
            write_q <= !set_idx[IDX_W-1];
            set_q   <= set_idx[SET_W-1:0];
        end
    end

    for (genvar s = 0; s < N_SETS; s++) begin : g_perm
        assign read_ok[s]  = valid_q && (set_q == SET_W'(s));
        assign write_ok[s] = valid_q && write_q && (set_q == SET_W'(s));
    end

    assign grant_valid = valid_q;
    assign grant_write = valid_q && write_q;
    assign grant_set   = set_q;
    assign rw_ok       = rw_req && valid_q && write_q && (rw_set == set_q);

    AST_ONE_READER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(read_ok));                                                     // R6
    AST_WRITE_HAS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (write_ok & ~read_ok) == '0);                                           // R8
    AST_REWRITE_AUTH: assert property (@(posedge clk) disable iff (!rst_n)
        rw_ok |-> (grant_valid && grant_write));                                // R11
endmodule

// File: rtl/pwd_guard.sv
module pwd_guard #(
    parameter int N_SETS     = 8,
    parameter int PW_W       = 24,
    parameter int CNT_W      = 8,
    parameter int UPD_CYCLES = 4,
    localparam int SET_W     = $clog2(N_SETS),
    localparam int IDX_W     = SET_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              card_rst,
    input  logic              pres_valid,
    input  logic [IDX_W-1:0]  pres_sel,
    input  logic [PW_W-1:0]   pres_value,
    output logic              busy,
    output logic              grant_valid,
    output logic              grant_write,
    output logic [SET_W-1:0]  grant_set,
    output logic [N_SETS-1:0] read_ok,
    output logic [N_SETS-1:0] write_ok,
    input  logic              pw_wr_en,
    input  logic [IDX_W-1:0]  pw_wr_sel,
    input  logic [PW_W-1:0]   pw_wr_value,
    input  logic              init_we,
    input  logic              init_cnt,
    input  logic [IDX_W-1:0]  init_sel,
    input  logic [PW_W-1:0]   init_data,
    input  logic [IDX_W-1:0]  cnt_sel,
    output logic [CNT_W-1:0]  cnt_value
);
    logic [IDX_W-1:0] cmp_idx, upd_idx, grant_idx;
    logic [PW_W-1:0]  cmp_pw;
    logic [CNT_W-1:0] cmp_cnt, upd_cnt;
    logic             accept, upd_we, grant_we, rw_ok;

    pwd_fsm #(
        .PW_W(PW_W), .CNT_W(CNT_W), .IDX_W(IDX_W), .UPD_CYCLES(UPD_CYCLES)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .card_rst(card_rst),
        .pres_valid(pres_valid), .pres_idx(pres_sel), .pres_value(pres_value),
        .cmp_pw(cmp_pw), .cmp_cnt(cmp_cnt), .cmp_idx(cmp_idx),
        .busy(busy), .accept(accept),
        .upd_we(upd_we), .upd_idx(upd_idx), .upd_cnt(upd_cnt),
        .grant_we(grant_we), .grant_idx(grant_idx)
    );

    pwd_bank #(
        .N_SETS(N_SETS), .PW_W(PW_W), .CNT_W(CNT_W)
    ) u_bank (
        .clk(clk), .rst_n(rst_n),
        .init_we(init_we && !busy), .init_cnt(init_cnt),
        .init_idx(init_sel), .init_data(init_data),
        .upd_we(upd_we), .upd_idx(upd_idx), .upd_cnt(upd_cnt),
        .rw_we(rw_ok), .rw_idx(pw_wr_sel), .rw_value(pw_wr_value),
        .cmp_idx(cmp_idx), .cmp_pw(cmp_pw), .cmp_cnt(cmp_cnt),
        .rd_idx(cnt_sel), .rd_cnt(cnt_value)
    );

    pwd_grant #(
        .N_SETS(N_SETS)
    ) u_grant (
        .clk(clk), .rst_n(rst_n),
        .revoke(accept || card_rst),
        .set_we(grant_we), .set_idx(grant_idx),
        .rw_req(pw_wr_en && !busy), .rw_set(pw_wr_sel[SET_W-1:0]),
        .grant_valid(grant_valid), .grant_write(grant_write),
        .grant_set(grant_set), .read_ok(read_ok), .write_ok(write_ok),
        .rw_ok(rw_ok)
    );

    AST_QUIET_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !grant_valid);                                                 // R9
    AST_PRESENT_REVOKES: assert property (@(posedge clk) disable iff (!rst_n)
        (pres_valid && !busy) |=> !grant_valid);                                // R6
    AST_CARD_RST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        card_rst |=> !grant_valid);                                             // R7
endmodule

// File: tb/pwd_guard_bench.sv
module pwd_guard_bench;
    localparam int UPD = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        card_rst = 1'b0;
    logic        pres_valid = 1'b0;
    logic [3:0]  pres_sel = '0;
    logic [23:0] pres_value = '0;
    logic        busy, grant_valid, grant_write;
    logic [2:0]  grant_set;
    logic [7:0]  read_ok, write_ok;
    logic        pw_wr_en = 1'b0;
    logic [3:0]  pw_wr_sel = '0;
    logic [23:0] pw_wr_value = '0;
    logic        init_we = 1'b0;
    logic        init_cnt = 1'b0;
    logic [3:0]  init_sel = '0;
    logic [23:0] init_data = '0;
    logic [3:0]  cnt_sel = '0;
    logic [7:0]  cnt_value;

    int total = 0;
    int bad = 0;
    bit ended = 0;

    always #2.5 clk = ~clk;

    pwd_guard #(.UPD_CYCLES(UPD)) u_pwd_guard (
        .clk(clk), .rst_n(rst_n), .card_rst(card_rst),
        .pres_valid(pres_valid), .pres_sel(pres_sel), .pres_value(pres_value),
        .busy(busy), .grant_valid(grant_valid), .grant_write(grant_write),
        .grant_set(grant_set), .read_ok(read_ok), .write_ok(write_ok),
        .pw_wr_en(pw_wr_en), .pw_wr_sel(pw_wr_sel), .pw_wr_value(pw_wr_value),
        .init_we(init_we), .init_cnt(init_cnt), .init_sel(init_sel),
        .init_data(init_data), .cnt_sel(cnt_sel), .cnt_value(cnt_value)
    );

    function automatic logic [23:0] pw_of(input int i);
        return 24'h5A0000 ^ 24'(i * 32'h010203);
    endfunction

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", what, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!ended) begin
            ended = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic rd_cnt(input logic [3:0] s, output logic [7:0] v);
        cnt_sel = s;
        #1;
        v = cnt_value;
    endtask

    task automatic wait_idle(output int nb, output bit seen_grant);
        nb = 0;
        seen_grant = 0;
        while (busy && nb < 100) begin
            if (grant_valid) seen_grant = 1;
            nb++;
            @(negedge clk);
        end
    endtask

    task automatic present(input logic [3:0] s, input logic [23:0] v, output int nb);
        bit sg;
        @(negedge clk);
        pres_valid = 1'b1; pres_sel = s; pres_value = v;
        @(negedge clk);
        pres_valid = 1'b0;
        wait_idle(nb, sg);
        chk("R9 grant hidden while busy", 32'(sg), 32'd0);
    endtask

    task automatic init_write(input logic kind, input logic [3:0] s, input logic [23:0] d);
        @(negedge clk);
        init_we = 1'b1; init_cnt = kind; init_sel = s; init_data = d;
        @(negedge clk);
        init_we = 1'b0;
    endtask

    task automatic rewrite(input logic [3:0] s, input logic [23:0] d);
        @(negedge clk);
        pw_wr_en = 1'b1; pw_wr_sel = s; pw_wr_value = d;
        @(negedge clk);
        pw_wr_en = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1 busy after reset", 32'(busy), 32'd0);
        chk("R1 grant after reset", 32'(grant_valid), 32'd0);
        chk("R1 perms after reset", {16'd0, read_ok, write_ok}, 32'd0);
        for (int i = 0; i < 16; i++) begin
            rd_cnt(4'(i), v);
            chk("R1 counter after reset", 32'(v), 32'hFF);
        end
        for (int i = 0; i < 16; i++) init_write(1'b0, 4'(i), pw_of(i));
    endtask

    task automatic t_good_write();
        int nb;
        logic [7:0] v;
        present(4'b0011, pw_of(3), nb);
        chk("R9 busy length", 32'(nb), 32'(UPD + 2));
        chk("R3 write grant", {28'd0, grant_valid, grant_write, 2'd0}, {28'd0, 1'b1, 1'b1, 2'd0});
        chk("R3 grant set", 32'(grant_set), 32'd3);
        chk("R8 write perms", {16'd0, read_ok, write_ok}, {16'd0, 8'h08, 8'h08});
        rd_cnt(4'b0011, v);
        chk("R3 counter full", 32'(v), 32'hFF);
    endtask

    task automatic t_wrong_read();
        int nb;
        logic [7:0] v;
        present(4'b1101, 24'h000BAD, nb);
        chk("R6 previous grant revoked", 32'(grant_valid), 32'd0);
        rd_cnt(4'b1101, v);
        chk("R4 first failure", 32'(v), 32'hFE);
        present(4'b1101, 24'h000BAE, nb);
        rd_cnt(4'b1101, v);
        chk("R4 second failure", 32'(v), 32'hFC);
    endtask

    task automatic t_good_read();
        int nb;
        logic [7:0] v;
        present(4'b1101, pw_of(13), nb);
        rd_cnt(4'b1101, v);
        chk("R3 counter restored", 32'(v), 32'hFF);
        chk("R3 read grant", {30'd0, grant_valid, grant_write}, {30'd0, 1'b1, 1'b0});
        chk("R8 read perms", {16'd0, read_ok, write_ok}, {16'd0, 8'h20, 8'h00});
        repeat (20) @(negedge clk);
        chk("R13 grant held", {29'd0, grant_valid, grant_set}, {29'd0, 1'b1, 3'd5});
    endtask

    task automatic t_exhaust();
        int nb;
        logic [7:0] v;
        init_write(1'b1, 4'b1010, 24'h000080);
        rd_cnt(4'b1010, v);
        chk("R12 counter preload", 32'(v), 32'h80);
        present(4'b1010, 24'h123123, nb);
        rd_cnt(4'b1010, v);
        chk("R4 last bit cleared", 32'(v), 32'h00);
        present(4'b1010, pw_of(10), nb);
        chk("R5 single busy cycle", 32'(nb), 32'd1);
        rd_cnt(4'b1010, v);
        chk("R5 counter frozen", 32'(v), 32'h00);
        chk("R5 no grant", 32'(grant_valid), 32'd0);
    endtask

    task automatic t_card_rst();
        int nb;
        bit sg;
        logic [7:0] v;
        present(4'b0001, pw_of(1), nb);
        chk("R3 grant before card reset", 32'(grant_valid), 32'd1);
        @(negedge clk); card_rst = 1'b1;
        @(negedge clk); card_rst = 1'b0;
        chk("R7 card reset clears", 32'(grant_valid), 32'd0);
        init_write(1'b1, 4'b0001, 24'h0000F0);
        @(negedge clk);
        pres_valid = 1'b1; pres_sel = 4'b0001; pres_value = pw_of(1);
        @(negedge clk);
        pres_valid = 1'b0; card_rst = 1'b1;
        @(negedge clk);
        card_rst = 1'b0;
        wait_idle(nb, sg);
        chk("R7 pending grant cancelled", 32'(grant_valid), 32'd0);
        rd_cnt(4'b0001, v);
        chk("R7 counter still updated", 32'(v), 32'hFF);
    endtask

    task automatic t_busy_ignore();
        int nb;
        bit sg;
        logic [7:0] v;
        @(negedge clk);
        pres_valid = 1'b1; pres_sel = 4'b0100; pres_value = pw_of(4);
        @(negedge clk);
        pres_sel = 4'b0110; pres_value = 24'h0;
        init_we = 1'b1; init_cnt = 1'b1; init_sel = 4'b0110; init_data = 24'h11;
        @(negedge clk);
        pres_valid = 1'b0; init_we = 1'b0;
        wait_idle(nb, sg);
        chk("R10 first presentation kept", {28'd0, grant_valid, grant_set}, {28'd0, 1'b1, 3'd4});
        rd_cnt(4'b0110, v);
        chk("R10 busy-time requests ignored", 32'(v), 32'hFF);
    endtask

    task automatic t_secure_rewrite();
        int nb;
        logic [7:0] v;
        present(4'b0111, pw_of(7), nb);
        chk("R2 secure code grants set 7", {16'd0, write_ok, 7'd0, grant_write}, {16'd0, 8'h80, 7'd0, 1'b1});
        rewrite(4'b1111, 24'h123456);
        rewrite(4'b0011, 24'h000000);
        chk("R13 grant kept over rewrite", 32'(grant_valid), 32'd1);
        present(4'b1111, 24'h123456, nb);
        chk("R11 rewritten password accepted", {28'd0, grant_valid, grant_set}, {28'd0, 1'b1, 3'd7});
        present(4'b0011, pw_of(3), nb);
        chk("R11 foreign rewrite ignored", {28'd0, grant_valid, grant_set}, {28'd0, 1'b1, 3'd3});
        rd_cnt(4'b0011, v);
        chk("R11 counter untouched", 32'(v), 32'hFF);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_good_write();
        t_wrong_read();
        t_good_read();
        t_exhaust();
        t_card_rst();
        t_busy_ignore();
        t_secure_rewrite();
        finish_up();
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=running exp=done");
        finish_up();
    end
endmodule